// File: doc/BRIEF.md
# SHA3-512 Rate Block Padder

This block sits in front of a SHA3-512 sponge permutation and turns a byte message, delivered as 32-bit words, into 576-bit rate blocks. Each accepted word is pushed in at the low end of a wide buffer after the held contents move up by one word, so the first word of a block ends up in the most significant bits. Once eighteen words have been collected, the full block is presented downstream. The buffer stays frozen until the permutation stage takes it, and only then does collection of the next block begin.

The message ends with a terminating beat that carries zero to three trailing bytes. On that beat the block inserts the SHA-3 domain byte 0x06 directly behind the last message byte and fills the rest of the block with zeros. It then sets the top bit of the block's final byte, so the closing byte reads 0x80, or 0x86 when the domain byte itself lands there. A message that fills its last block exactly therefore produces one extra block that holds padding only. A completion flag accompanies the final block.

Both data paths use valid/ready rules. An input word transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low for as long as a block is held, and a sender must hold its word until it sees ready. The output block transfers on an edge where `blk_valid` and `blk_ack` are both high. While `blk_valid` is high, `blk_data` and `msg_done` do not change. `blk_ack` has no effect while `blk_valid` is low.

Top module: `sha3_rate_padder`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `blk_valid` and `msg_done` are 0.
- R2: Message byte k of a block (k = 0 for the first) sits at `blk_data[575-8k -: 8]`. Within a word, the first byte is bits 31:24, and a newly accepted word enters at the low end after a 32-bit left shift.
- R3: Accepting the 18th non-final word of a block raises `blk_valid` and drops `in_ready` on the same edge. Before that edge `blk_valid` stays 0.
- R4: While a block is held without acknowledge, `blk_data`, `blk_valid` and `msg_done` stay unchanged and `in_valid` pulses are not absorbed.
- R5: A beat with `in_last` = 1 carries `in_nbytes` (0..3) valid bytes in its upper byte lanes. The block then holds those bytes, 0x06 in the next byte position, zeros after it, and bit 7 of byte 71 (`blk_data[7]`) set.
- R6: When 17 words are followed by a final beat with 3 bytes, byte 71 of the block is 0x86.
- R7: A final beat with 0 bytes at the start of a block yields a block that is 0x06 in byte 0, 0x80 in byte 71 and zero elsewhere.
- R8: `msg_done` is 1 exactly while the block produced by a final beat is held, and it is 0 for full-data blocks and after acknowledge.
- R9: An acknowledged block leaves no trace: the next block holds only its own bytes and padding.
- R10: A reset asserted in the middle of a block discards the partly collected words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Padder can take a beat |
| in_data | input | 32 | Message word, first byte in bits 31:24 |
| in_last | input | 1 | Beat ends the message |
| in_nbytes | input | 2 | Valid bytes on a final beat (0..3) |
| blk_valid | output | 1 | Rate block held for the permutation stage |
| blk_data | output | 576 | Rate block, byte 0 in bits 575:568 |
| blk_ack | input | 1 | Permutation stage takes the block |
| msg_done | output | 1 | Held block is the last one of the message |

## Verification
The bench looks for the placement of the domain byte for each of the four trailing-byte counts. A design that counted byte lanes from the wrong end would put 0x06 over message data or leave a gap before it. The collision of the domain byte with the closing bit in the last byte is checked as 0x86; a design that overwrote instead of combining would show 0x06 or 0x80 there. An exact-boundary message must produce a padding-only block whose upper bits are clean, which exposes a buffer not cleared after acknowledge. Input pulses during a held block and a reset in the middle of a block catch a design that absorbs words under back-pressure or keeps stale words across reset.

// File: rtl/sha3pad_pkg.sv
package sha3pad_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam logic [7:0]  DOMAIN_BYTE = 8'h06;
  localparam logic [7:0]  CLOSE_BYTE  = 8'h80;
endpackage

// File: rtl/pad_word_gen.sv
module pad_word_gen
  import sha3pad_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LANES = WORD_W / BYTE_W,
  localparam int unsigned NB_W  = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [NB_W-1:0]   nbytes_i,
  output logic [WORD_W-1:0] word_o
);
  // lane 0 is the most significant byte, the first byte on the wire
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned HI = WORD_W - 1 - g * BYTE_W;
    always_comb begin
      if (g < int'(nbytes_i))
        word_o[HI -: BYTE_W] = word_i[HI -: BYTE_W];
      else if (g == int'(nbytes_i))
        word_o[HI -: BYTE_W] = DOMAIN_BYTE;
      else
        word_o[HI -: BYTE_W] = '0;
    end
  end
endmodule

// File: rtl/rate_buffer.sv
module rate_buffer
  import sha3pad_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned RATE_W = 576,
  localparam int unsigned WORDS = RATE_W / WORD_W,
  localparam int unsigned CNT_W = $clog2(WORDS + 1),
  localparam int unsigned SH_W  = $clog2(RATE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              seal_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] pad_word_i,
  output logic [RATE_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [RATE_W-1:0] buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RATE_W-1:0] joined;
  logic [RATE_W-1:0] sealed;
  logic [CNT_W-1:0]  gap;
  logic [SH_W-1:0]   shamt;

  always_comb begin
    joined = {buf_q[RATE_W-WORD_W-1:0], pad_word_i};
    gap    = CNT_W'(WORDS - 1) - cnt_q;
    shamt  = SH_W'(int'(gap) * WORD_W);
    sealed = (joined << shamt) | RATE_W'(CLOSE_BYTE);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (seal_i) begin
      buf_q <= sealed;
      cnt_q <= CNT_W'(WORDS);
    end else if (push_i) begin
      buf_q <= {buf_q[RATE_W-WORD_W-1:0], word_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o = buf_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/padder_ctrl.sv
module padder_ctrl #(
  parameter int unsigned WORDS = 18,
  localparam int unsigned CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             blk_ack,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             in_ready,
  output logic             push_o,
  output logic             seal_o,
  output logic             clr_o,
  output logic             blk_valid,
  output logic             msg_done
);
  logic hold_q;
  logic done_q;
  logic take;

  assign in_ready = !hold_q;
  assign take     = in_valid && !hold_q;
  assign push_o   = take && !in_last;
  assign seal_o   = take && in_last;
  assign clr_o    = hold_q && blk_ack;

  always_ff @(posedge clk) begin
    if (rst || clr_o) begin
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else if (seal_o) begin
      hold_q <= 1'b1;
      done_q <= 1'b1;
    end else if (push_o && cnt_i == CNT_W'(WORDS - 1)) begin
      hold_q <= 1'b1;
    end
  end

  assign blk_valid = hold_q;
  assign msg_done  = done_q;
endmodule

// File: rtl/sha3_rate_padder.sv
module sha3_rate_padder #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned RATE_W = 576,
  localparam int unsigned WORDS = RATE_W / WORD_W,
  localparam int unsigned CNT_W = $clog2(WORDS + 1),
  localparam int unsigned NB_W  = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [NB_W-1:0]   in_nbytes,
  output logic              blk_valid,
  output logic [RATE_W-1:0] blk_data,
  input  logic              blk_ack,
  output logic              msg_done
);
  logic [WORD_W-1:0] pad_word;
  logic [CNT_W-1:0]  cnt;
  logic              push;
  logic              seal;
  logic              clr;

  pad_word_gen #(.WORD_W(WORD_W)) u_padw (
    .word_i   (in_data),
    .nbytes_i (in_nbytes),
    .word_o   (pad_word)
  );

  rate_buffer #(.WORD_W(WORD_W), .RATE_W(RATE_W)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .push_i     (push),
    .seal_i     (seal),
    .word_i     (in_data),
    .pad_word_i (pad_word),
    .data_o     (blk_data),
    .cnt_o      (cnt)
  );

  padder_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .blk_ack   (blk_ack),
    .cnt_i     (cnt),
    .in_ready  (in_ready),
    .push_o    (push),
    .seal_o    (seal),
    .clr_o     (clr),
    .blk_valid (blk_valid),
    .msg_done  (msg_done)
  );
endmodule

// File: rtl/sha3_rate_padder_chk.sv
module sha3_rate_padder_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned RATE_W = 576,
  localparam int unsigned NB_W  = $clog2(WORD_W / 8)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic              in_last,
  input logic [NB_W-1:0]   in_nbytes,
  input logic              blk_valid,
  input logic [RATE_W-1:0] blk_data,
  input logic              blk_ack,
  input logic              msg_done
);
  // R4
  held_block_stable_chk: assert property (@(posedge clk) disable iff (rst)
    blk_valid && !blk_ack |=> blk_valid && $stable(blk_data) && $stable(msg_done));

  // R8
  done_with_block_chk: assert property (@(posedge clk) disable iff (rst)
    msg_done |-> blk_valid);

  // R5
  close_bit_chk: assert property (@(posedge clk) disable iff (rst)
    msg_done |-> blk_data[7]);

  // R8
  final_beat_done_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_last |=> blk_valid && msg_done);

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    blk_valid && blk_ack |=> !blk_valid && !msg_done);
endmodule

bind sha3_rate_padder sha3_rate_padder_chk #(.WORD_W(WORD_W), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/sha3_rate_padder_test.sv
module sha3_rate_padder_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_data = '0;
  logic         in_last = 1'b0;
  logic [1:0]   in_nbytes = '0;
  logic         blk_valid;
  logic [575:0] blk_data;
  logic         blk_ack = 1'b0;
  logic         msg_done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mb [0:71];
  int nb = 0;

  always #10 clk = ~clk;

  sha3_rate_padder uut (.*);

  task automatic chk(string req, logic [575:0] act, logic [575:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [575:0] exp_block(int nvalid, bit padded);
    logic [575:0] e = '0;
    for (int k = 0; k < 72; k++) begin
      logic [7:0] b;
      if (k < nvalid) b = mb[k];
      else if (padded && k == nvalid) b = 8'h06;
      else b = 8'h00;
      if (padded && k == 71) b = b | 8'h80;
      e[575-8*k -: 8] = b;
    end
    return e;
  endfunction

  task automatic put_word(logic [31:0] d);
    in_valid = 1'b1; in_last = 1'b0; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    for (int b = 0; b < 4; b++) mb[nb + b] = d[31-8*b -: 8];
    nb += 4;
  endtask

  task automatic put_last(logic [31:0] d, int n);
    in_valid = 1'b1; in_last = 1'b1; in_data = d; in_nbytes = 2'(n);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    for (int b = 0; b < n; b++) mb[nb + b] = d[31-8*b -: 8];
    nb += n;
  endtask

  task automatic ack_block();
    blk_ack = 1'b1;
    @(negedge clk);
    blk_ack = 1'b0;
    nb = 0;
  endtask

  task automatic t_reset();
    chk("R1 in_ready", 576'(in_ready), 576'(1));
    chk("R1 blk_valid", 576'(blk_valid), 576'(0));
    chk("R1 msg_done", 576'(msg_done), 576'(0));
  endtask

  task automatic t_full_then_pad();
    logic [575:0] held;
    for (int i = 0; i < 17; i++)
      put_word({8'(i) ^ 8'hF0, 8'h5A, 8'hFF, 8'(i)});
    chk("R3 not yet valid", 576'(blk_valid), 576'(0));
    chk("R3 ready before full", 576'(in_ready), 576'(1));
    put_word(32'hFFFF_FFFF);
    chk("R3 valid at 18", 576'(blk_valid), 576'(1));
    chk("R3 ready low", 576'(in_ready), 576'(0));
    chk("R2 word order", blk_data, exp_block(72, 1'b0));
    chk("R8 no done on data block", 576'(msg_done), 576'(0));
    held = blk_data;
    in_valid = 1'b1; in_data = 32'h1234_5678;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk("R4 data held", blk_data, held);
    chk("R4 still valid", 576'({blk_valid, msg_done}), 576'(2'b10));
    ack_block();
    chk("R9 released", 576'({blk_valid, in_ready}), 576'(2'b01));
    put_last(32'hAAAA_AAAA, 0);
    chk("R7 pad-only block", blk_data, exp_block(0, 1'b1));
    chk("R8 done with final", 576'({blk_valid, msg_done}), 576'(2'b11));
    ack_block();
    chk("R8 done cleared", 576'({blk_valid, msg_done}), 576'(2'b00));
  endtask

  task automatic t_partial(int nwords, int n);
    for (int i = 0; i < nwords; i++) put_word(32'hC0DE_0000 + 32'(i * 'h111) + 32'(n));
    put_last(32'hDEAD_BEEF, n);
    chk($sformatf("R5 %0d words %0d bytes", nwords, n), blk_data, exp_block(nb, 1'b1));
    chk("R8 done partial", 576'(msg_done), 576'(1));
    ack_block();
  endtask

  task automatic t_one_pad_byte();
    for (int i = 0; i < 17; i++) put_word(32'h0102_0304 * 32'(i + 1));
    put_last(32'h7778_7900, 3);
    chk("R6 last byte", 576'(blk_data[7:0]), 576'(8'h86));
    chk("R6 block", blk_data, exp_block(71, 1'b1));
    ack_block();
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 4; i++) put_word(32'hFACE_0000 + 32'(i));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    nb = 0;
    chk("R10 cleared", 576'({in_ready, blk_valid, msg_done}), 576'(3'b100));
    put_last(32'hAB00_0000, 1);
    chk("R10 no stale words", blk_data, exp_block(1, 1'b1));
    ack_block();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_then_pad();
    t_partial(3, 0);
    t_partial(5, 1);
    t_partial(9, 2);
    t_partial(1, 3);
    t_partial(0, 2);
    t_one_pad_byte();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule